// File: doc/BRIEF.md
# Multi-word load burst splitter

This block turns an uncached load-multiple request into one or two read address requests for an AXI-style read channel. A request carries a word-aligned start byte address, a word count from 1 to 8 and a flag that marks the target as device or strongly ordered memory. For each request the block works out the address, the burst type, the transfer size and the transfer count. The result is always an incrementing burst.

The request sits inside a 32-byte line of eight 32-bit words. A load that would run past the last word of that line is split in two pieces. The first piece covers the start word up to the end of the line. The second piece carries the remaining words and starts at byte 0 of the same line. Device-type loads use 32-bit beats. Other loads use 64-bit beats whenever a piece holds more than one word.

Both edges use a valid/ready handshake. A request is accepted only while the block is idle. It then offers its pieces one at a time, in order, on the address output.

Top module: `ldm_burst_splitter`

## Requirements
- R1: Every request offered on the address output has burst type INCR, encoded as 2'b01.
- R2: For a device-flagged request, every piece uses size code 3'b010 (32-bit), and its length field is the piece's word count minus one (the length field always holds transfers minus one).
- R3: For a request without the device flag, a piece of two or more words uses size code 3'b011 (64-bit). Its length field is the number of 8-byte doublewords the piece touches, minus one. That count is taken from the piece's start address rounded down to 8 bytes.
- R4: With start word index w = address bits [4:2] and count n, a request is split exactly when w + n > 8. The first (or only) piece is issued at the request address and holds min(n, 8 - w) words.
- R5: The second piece of a split holds n - (8 - w) words. Its address keeps every bit above bit 4 of the request address, and address bits [4:0] are zero.
- R6: A piece of exactly one word is issued with size code 3'b010 and length field 0, whatever the memory type.
- R7: Pieces are offered in order, first piece first. Each piece stays on the output with unchanged fields until ar_ready is seen. The output goes idle after the last piece is taken.
- R8: req_ready is high only while no piece is pending. A request offered while pieces are pending is not taken and does not change the output.
- R9: After reset, ar_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Word-aligned start byte address |
| req_words | input | CNT_W | Word count, 1 to LINE_WORDS |
| req_device | input | 1 | Target is device or strongly ordered memory |
| ar_valid | output | 1 | Read address piece present |
| ar_ready | input | 1 | Downstream takes the piece |
| ar_addr | output | ADDR_W | Piece start address |
| ar_burst | output | 2 | Burst type, always INCR (2'b01) |
| ar_size | output | 3 | Beat size code: 3'b010 = 32-bit, 3'b011 = 64-bit |
| ar_len | output | 8 | Transfer count minus one |

## Verification
The bench tries every start word and every word count, for both memory types, with different upper address bits on each run. This covers every split point. It also tells odd from even start words, which changes the doubleword count, and it exercises each single-word tail or head. Each piece is held for zero, one or two stall cycles, so the bench can tell a piece that drifts or jumps ahead from one that waits for its handshake. While pieces are pending, a different request is held on the input so that any early acceptance would show on the output.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [2:0] SIZE_W32   = 3'b010;
    localparam logic [2:0] SIZE_W64   = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } split_st_e;

    typedef struct packed {
        logic [2:0] size;
        logic [7:0] len;
    } shape_t;

endpackage

// File: rtl/lsplit_piece.sv
module lsplit_piece
    import lsplit_pkg::*;
#(
    parameter int WIDX_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic [WIDX_W-1:0] start_word,
    input  logic [CNT_W-1:0]  count,
    input  logic              device,
    output shape_t            shape
);

    logic [CNT_W-1:0] start_ext;
    logic [CNT_W-1:0] last_word;
    logic [CNT_W-1:0] dword_cnt;

    always_comb begin
        start_ext = CNT_W'(start_word);
        last_word = start_ext + count - CNT_W'(1);
        dword_cnt = (last_word >> 1) - (start_ext >> 1) + CNT_W'(1);
        if (count <= CNT_W'(1) || device) begin
            shape.size = SIZE_W32;
            shape.len  = 8'(count - CNT_W'(1));
        end else begin
            shape.size = SIZE_W64;
            shape.len  = 8'(dword_cnt - CNT_W'(1));
        end
    end

endmodule

// File: rtl/lsplit_plan.sv
module lsplit_plan
    import lsplit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int WIDX_W     = 3,
    parameter int CNT_W      = 4,
    parameter int OFF_W      = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  words,
    input  logic              device,
    output logic              split,
    output logic [ADDR_W-1:0] head_addr,
    output logic [ADDR_W-1:0] tail_addr,
    output shape_t            head_shape,
    output shape_t            tail_shape
);

    localparam logic [CNT_W-1:0] LW = CNT_W'(LINE_WORDS);

    logic [WIDX_W-1:0] widx;
    logic [CNT_W-1:0]  room;
    logic [WIDX_W-1:0] pc_start [2];
    logic [CNT_W-1:0]  pc_cnt   [2];
    shape_t            pc_shape [2];

    always_comb begin
        widx        = addr[OFF_W-1:2];
        room        = LW - CNT_W'(widx);
        split       = words > room;
        pc_start[0] = widx;
        pc_start[1] = '0;
        pc_cnt[0]   = split ? room : words;
        pc_cnt[1]   = split ? (words - room) : CNT_W'(1);
        head_addr   = addr;
        tail_addr   = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    for (genvar g = 0; g < 2; g++) begin : g_piece
        lsplit_piece #(
            .WIDX_W (WIDX_W),
            .CNT_W  (CNT_W)
        ) u_piece (
            .start_word (pc_start[g]),
            .count      (pc_cnt[g]),
            .device     (device),
            .shape      (pc_shape[g])
        );
    end

    assign head_shape = pc_shape[0];
    assign tail_shape = pc_shape[1];

endmodule

// File: rtl/ldm_burst_splitter.sv
module ldm_burst_splitter
    import lsplit_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_WORDS = 8,
    localparam int WIDX_W     = $clog2(LINE_WORDS),
    localparam int CNT_W      = WIDX_W + 1,
    localparam int OFF_W      = WIDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_words,
    input  logic              req_device,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [2:0]        ar_size,
    output logic [7:0]        ar_len
);

    typedef struct packed {
        split_st_e         st;
        logic              split;
        logic [ADDR_W-1:0] head_addr;
        logic [ADDR_W-1:0] tail_addr;
        shape_t            head_shape;
        shape_t            tail_shape;
    } regs_t;

    regs_t             d, q;
    logic              pl_split;
    logic [ADDR_W-1:0] pl_head_addr;
    logic [ADDR_W-1:0] pl_tail_addr;
    shape_t            pl_head_shape;
    shape_t            pl_tail_shape;

    lsplit_plan #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS),
        .WIDX_W     (WIDX_W),
        .CNT_W      (CNT_W),
        .OFF_W      (OFF_W)
    ) u_plan (
        .addr       (req_addr),
        .words      (req_words),
        .device     (req_device),
        .split      (pl_split),
        .head_addr  (pl_head_addr),
        .tail_addr  (pl_tail_addr),
        .head_shape (pl_head_shape),
        .tail_shape (pl_tail_shape)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st         = ST_HEAD;
                    d.split      = pl_split;
                    d.head_addr  = pl_head_addr;
                    d.tail_addr  = pl_tail_addr;
                    d.head_shape = pl_head_shape;
                    d.tail_shape = pl_tail_shape;
                end
            end
            ST_HEAD: begin
                if (ar_ready) d.st = q.split ? ST_TAIL : ST_IDLE;
            end
            ST_TAIL: begin
                if (ar_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready = (q.st == ST_IDLE);
        ar_valid  = (q.st != ST_IDLE);
        ar_burst  = BURST_INCR;
        if (q.st == ST_TAIL) begin
            ar_addr = q.tail_addr;
            ar_size = q.tail_shape.size;
            ar_len  = q.tail_shape.len;
        end else begin
            ar_addr = q.head_addr;
            ar_size = q.head_shape.size;
            ar_len  = q.head_shape.len;
        end
    end

    // R7: a stalled piece stays put
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_size) && $stable(ar_len));

    // R8: no request is taken while a piece is pending
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !req_ready);

    // R4: first piece starts at the accepted address
    a_r4_head_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> ar_valid && ar_addr == $past(req_addr));

    // R5: second piece begins at line offset zero
    a_r5_tail_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_TAIL |-> ar_addr[OFF_W-1:0] == '0);

endmodule

// File: tb/ldm_burst_splitter_test.sv
`timescale 1ns/1ps
module ldm_burst_splitter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_words = '0;
    logic        req_device = 1'b0;
    logic        ar_valid;
    logic        ar_ready = 1'b0;
    logic [31:0] ar_addr;
    logic [1:0]  ar_burst;
    logic [2:0]  ar_size;
    logic [7:0]  ar_len;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ldm_burst_splitter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_words  (req_words),
        .req_device (req_device),
        .ar_valid   (ar_valid),
        .ar_ready   (ar_ready),
        .ar_addr    (ar_addr),
        .ar_burst   (ar_burst),
        .ar_size    (ar_size),
        .ar_len     (ar_len)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_one(int w, int n, bit dev, int it);
        logic [31:0] base, addr;
        logic [31:0] ea [2];
        int          ecnt [2];
        int          estart [2];
        int          np, room;
        base = 32'h4000_0000 + (it * 32'h0000_0460);
        base[4:0] = 5'd0;
        addr = base | (w << 2);
        room = 8 - w;
        if (w + n > 8) begin
            np = 2;
            ea[0] = addr; estart[0] = w; ecnt[0] = room;
            ea[1] = base; estart[1] = 0; ecnt[1] = n - room;
        end else begin
            np = 1;
            ea[0] = addr; estart[0] = w; ecnt[0] = n;
            ea[1] = base; estart[1] = 0; ecnt[1] = 0;
        end

        @(negedge clk);
        check("R8", "req_ready idle", 32'(req_ready), 32'd1);
        req_valid  = 1'b1;
        req_addr   = addr;
        req_words  = 4'(n);
        req_device = dev;
        @(negedge clk);
        // competing request held during the busy period (R8)
        req_addr   = ~addr;
        req_words  = 4'd3;
        req_device = ~dev;

        for (int p = 0; p < np; p++) begin
            int stall;
            int k, s0;
            logic [2:0] esz;
            logic [7:0] eln;
            string atag, stag;
            stall = (it + p) % 3;
            k  = ecnt[p];
            s0 = estart[p];
            if (k == 1) begin
                esz = 3'b010; eln = 8'd0; stag = "R6";
            end else if (dev) begin
                esz = 3'b010; eln = 8'(k - 1); stag = "R2";
            end else begin
                esz = 3'b011; eln = 8'(((s0 + k - 1) / 2) - (s0 / 2)); stag = "R3";
            end
            atag = (p == 0) ? "R4" : "R5";
            for (int s = 0; s <= stall; s++) begin
                check("R7", "ar_valid", 32'(ar_valid), 32'd1);
                check(atag, "ar_addr", ar_addr, ea[p]);
                check(stag, "ar_size", 32'(ar_size), 32'(esz));
                check(stag, "ar_len", 32'(ar_len), 32'(eln));
                check("R1", "ar_burst", 32'(ar_burst), 32'd1);
                check("R8", "req_ready busy", 32'(req_ready), 32'd0);
                if (s == stall) begin
                    ar_ready = 1'b1;
                    if (p == np - 1) req_valid = 1'b0;
                end
                @(negedge clk);
                ar_ready = 1'b0;
            end
        end
        check("R7", "ar_valid after last", 32'(ar_valid), 32'd0);
        check("R8", "req_ready after last", 32'(req_ready), 32'd1);
    endtask

    initial begin
        int it;
        it = 0;
        repeat (3) @(negedge clk);
        check("R9", "ar_valid in reset", 32'(ar_valid), 32'd0);
        check("R9", "req_ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ar_valid after reset", 32'(ar_valid), 32'd0);
        check("R9", "req_ready after reset", 32'(req_ready), 32'd1);
        for (int dv = 0; dv < 2; dv++) begin
            for (int w = 0; w < 8; w++) begin
                for (int n = 1; n <= 8; n++) begin
                    run_one(w, n, dv[0], it);
                    it++;
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule